// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds a parameterised number of independent down-counters, two by default, each 32 bits wide. Each channel is programmed through a small register window: a control word, an interval word and a read-only live count. The control word enables the channel, requests a load of the interval, picks one of four tick strobes as its time base, sets a power-of-two divider and chooses between a repeating and a single-shot run. A shared pair of registers holds the per-channel interrupt enables and the sticky expiry flags. Software clears a flag by writing a one to its bit. One level-sensitive interrupt line reports any flag whose enable is set.

The tick strobes are single-clock enable pulses in the register clock domain. They stand in for the slower source clocks of a real part. When a channel's enable is cleared, the channel keeps counting for a short fixed number of its own source ticks before it halts. Software is expected to wait out this window, timed on another running channel, before it reprograms the channel. A channel loaded with an all-ones interval and left repeating acts as a free-running timebase. The bitwise inverse of its count rises steadily.

Top module: `multi_timer`

## Requirements
- R1: The interrupt-enable register (offset 0x00) keeps one bit per channel, and its unused upper bits read 0. Channel n's control register sits at 0x10*n+0x10 and its interval register at 0x10*n+0x14; both read back what was written. Control bit fields: bit 0 enable, bit 1 load command, bits [3:2] source select, bits [6:4] divider code, bit 7 single-shot. Control bits above 7 read 0.
- R2: Reads of any offset outside the map return 0, and writes to them change nothing. The count register at 0x10*n+0x18 is read-only.
- R3: Writing 1 to the load bit leaves it reading 1 until the next divided tick of a running channel. On that tick the interval is copied into the count and the bit reads 0.
- R4: A running channel decrements its count by one on each divided tick. On a divided tick while the count is 0 the channel expires. In repeating mode the count is then reloaded from the interval, so the period is interval+1 divided ticks.
- R5: In single-shot mode the expiry clears the enable bit, stops the channel with the count at 0, and produces no further expiries.
- R6: A channel advances only on the tick input named by its source field (bits [3:2]). Strobes on the other tick inputs have no effect on it.
- R7: The divider passes one of every 2^code source ticks (code in bits [6:4]). The first pass comes on the 2^code-th source tick after the channel starts running.
- R8: After the enable bit is cleared, the first selected source tick still counts and the second one halts the channel. The count then holds.
- R9: An expiry sets the channel's status bit (offset 0x04, bit n) whatever its enable. Writing 1 to a status bit clears it. An expiry in the same cycle as a clear leaves the bit set.
- R10: The interrupt output is high exactly when some channel has both its status bit and its enable bit set.
- R11: With an all-ones interval in repeating mode, the count runs down from 0xFFFFFFFF, so its inverse equals the number of divided ticks since the load minus one.
- R12: After reset all registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| tick_i | input | 4 | Tick-enable strobes, one per selectable source |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the tick inputs are one-cycle strobes in the register clock domain. They also assume that a change of the interrupt enables is the only thing that can keep an enabled expiry from raising the interrupt on the next cycle. The stimulus keeps within this. Each tick is a pulse one clock wide followed by a quiet clock. Writes are spaced by at least one idle cycle. Status clears coincide with an expiry only in the one test that checks set-over-clear priority. The divider and the disable window are always started from a halted channel, so the expected counts follow directly from the number of pulses issued.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int BUS_W      = 32;
    localparam int SRC_W      = 2;
    localparam int PRE_W      = 3;
    localparam int NUM_SRC    = 1 << SRC_W;
    localparam int DIV_W      = (1 << PRE_W) - 1;
    localparam int SYNC_TICKS = 2;

    localparam int OFF_IE   = 'h00;
    localparam int OFF_ST   = 'h04;
    localparam int SUB_CTL  = 'h0;
    localparam int SUB_INTV = 'h4;
    localparam int SUB_CNT  = 'h8;

    // field order fixes the bit positions of the control word
    typedef struct packed {
        logic             oneshot;
        logic [PRE_W-1:0] pre;
        logic [SRC_W-1:0] src;
        logic             reload;
        logic             en;
    } mt_ctl_t;

    localparam int CTL_W = $bits(mt_ctl_t);
endpackage

// File: rtl/mt_tick_div.sv
module mt_tick_div
    import mt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] code_i,
    output logic             ptick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] acc;
    } div_t;

    div_t             div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        div_d   = div_q;
        mask    = DIV_W'((32'd1 << code_i) - 32'd1);
        ptick_o = 1'b0;
        if (clear_i) begin
            div_d.acc = '0;
        end else if (tick_i) begin
            div_d.acc = div_q.acc + 1'b1;
            ptick_o   = ((div_q.acc & mask) == mask);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import mt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic               ctl_we_i,
    input  mt_ctl_t            ctl_wdata_i,
    input  logic               intv_we_i,
    input  logic [CNT_W-1:0]   intv_wdata_i,
    output mt_ctl_t            ctl_o,
    output logic [CNT_W-1:0]   intv_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               run_o,
    output logic               expire_o
);
    localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        mt_ctl_t           ctl;
        logic [CNT_W-1:0]  intv;
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic [SYNC_W-1:0] sync;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  src_tick, ptick, draining, halt;

    assign src_tick = tick_i[ch_q.ctl.src];

    mt_tick_div u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (!ch_q.run),
        .tick_i  (src_tick),
        .code_i  (ch_q.ctl.pre),
        .ptick_o (ptick)
    );

    always_comb begin
        ch_d     = ch_q;
        expire_o = 1'b0;
        draining = ch_q.run && !ch_q.ctl.en;
        halt     = draining && src_tick && (ch_q.sync == SYNC_W'(SYNC_TICKS - 1));

        // stopping window measured in selected source ticks
        if (draining) begin
            if (src_tick) begin
                if (halt) begin
                    ch_d.run  = 1'b0;
                    ch_d.sync = '0;
                end else begin
                    ch_d.sync = ch_q.sync + 1'b1;
                end
            end
        end else begin
            ch_d.sync = '0;
            ch_d.run  = ch_q.ctl.en;
        end

        if (ptick && !halt) begin
            if (ch_q.ctl.reload) begin
                ch_d.cnt        = ch_q.intv;
                ch_d.ctl.reload = 1'b0;
            end else if (ch_q.cnt == '0) begin
                expire_o = 1'b1;
                if (ch_q.ctl.oneshot) begin
                    ch_d.ctl.en = 1'b0;
                    ch_d.run    = 1'b0;
                    ch_d.sync   = '0;
                end else begin
                    ch_d.cnt = ch_q.intv;
                end
            end else begin
                ch_d.cnt = ch_q.cnt - 1'b1;
            end
        end

        // software writes take priority over the tick updates
        if (ctl_we_i) begin
            ch_d.ctl.en      = ctl_wdata_i.en;
            ch_d.ctl.src     = ctl_wdata_i.src;
            ch_d.ctl.pre     = ctl_wdata_i.pre;
            ch_d.ctl.oneshot = ctl_wdata_i.oneshot;
            if (ctl_wdata_i.reload) ch_d.ctl.reload = 1'b1;
        end
        if (intv_we_i) ch_d.intv = intv_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ch_q <= '0;
        else         ch_q <= ch_d;
    end

    assign ctl_o  = ch_q.ctl;
    assign intv_o = ch_q.intv;
    assign cnt_o  = ch_q.cnt;
    assign run_o  = ch_q.run;
endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import mt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    input  logic [NUM_SRC-1:0] tick_i,
    output logic               irq_o
);
    localparam int SEL_W = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] st;
    } top_t;

    top_t                         top_d, top_q;
    logic [SEL_W-1:0]             sel;
    logic [3:0]                   off;
    logic                         ie_wr, st_wr;
    logic [NUM_CH-1:0]            ie_cur, st_cur;
    logic [NUM_CH-1:0]            ch_run, ch_exp, ch_oneshot;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_intv;
    mt_ctl_t                      ch_ctl [NUM_CH];

    assign sel   = bus_addr_i[ADDR_W-1:4];
    assign off   = bus_addr_i[3:0];
    assign ie_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_IE));
    assign st_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_ST));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = (sel == SEL_W'(i + 1));

        mt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .tick_i       (tick_i),
            .ctl_we_i     (bus_we_i && hit && (off == 4'(SUB_CTL))),
            .ctl_wdata_i  (mt_ctl_t'(bus_wdata_i[CTL_W-1:0])),
            .intv_we_i    (bus_we_i && hit && (off == 4'(SUB_INTV))),
            .intv_wdata_i (bus_wdata_i[CNT_W-1:0]),
            .ctl_o        (ch_ctl[i]),
            .intv_o       (ch_intv[i]),
            .cnt_o        (ch_cnt[i]),
            .run_o        (ch_run[i]),
            .expire_o     (ch_exp[i])
        );
        assign ch_oneshot[i] = ch_ctl[i].oneshot;
    end

    always_comb begin
        top_d = top_q;
        if (ie_wr) top_d.ie = bus_wdata_i[NUM_CH-1:0];
        // a fresh expiry outranks a clear in the same cycle
        top_d.st = (top_q.st & ~(st_wr ? bus_wdata_i[NUM_CH-1:0] : '0)) | ch_exp;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    assign ie_cur = top_q.ie;
    assign st_cur = top_q.st;
    assign irq_o  = |(top_q.st & top_q.ie);

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFF_IE)) bus_rdata_o = BUS_W'(top_q.ie);
        if (bus_addr_i == ADDR_W'(OFF_ST)) bus_rdata_o = BUS_W'(top_q.st);
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                if (off == 4'(SUB_CTL))  bus_rdata_o = BUS_W'(ch_ctl[i]);
                if (off == 4'(SUB_INTV)) bus_rdata_o = BUS_W'(ch_intv[i]);
                if (off == 4'(SUB_CNT))  bus_rdata_o = BUS_W'(ch_cnt[i]);
            end
        end
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         irq_i,
    input logic                         ie_wr,
    input logic [NUM_CH-1:0]            ie_cur,
    input logic [NUM_CH-1:0]            st_cur,
    input logic [NUM_CH-1:0]            ch_run,
    input logic [NUM_CH-1:0]            ch_exp,
    input logic [NUM_CH-1:0]            ch_oneshot,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_intv
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_status_on_expire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ch_exp[i] |=> st_cur[i]);

        p_oneshot_halts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ch_exp[i] && ch_oneshot[i]) |=> !ch_run[i]);

        p_idle_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ch_run[i] |=> $stable(ch_cnt[i]));

        p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(ch_cnt[i]) |->
                ((ch_cnt[i] == $past(ch_cnt[i]) - CNT_W'(1)) || (ch_cnt[i] == $past(ch_intv[i]))));

        p_irq_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ch_exp[i] && ie_cur[i] && !ie_wr) |=> irq_i);
    end
endmodule

bind multi_timer mt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_o),
    .ie_wr      (ie_wr),
    .ie_cur     (ie_cur),
    .st_cur     (st_cur),
    .ch_run     (ch_run),
    .ch_exp     (ch_exp),
    .ch_oneshot (ch_oneshot),
    .ch_cnt     (ch_cnt),
    .ch_intv    (ch_intv)
);

// File: tb/tb_multi_timer.sv
module tb_multi_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tick = '0;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    multi_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_i      (tick),
        .irq_o       (irq)
    );

    // {req, addr, write data, expected readback}
    localparam int NV = 15;
    localparam logic [79:0] VEC [NV] = '{
        {8'd1, 8'h14, 32'h0000_1234, 32'h0000_1234},  // R1 ch0 interval
        {8'd1, 8'h24, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R1 ch1 interval
        {8'd1, 8'h10, 32'h0000_00F4, 32'h0000_00F4},  // R1 ch0 control fields
        {8'd1, 8'h10, 32'h0000_FF00, 32'h0000_0000},  // R1 upper control bits
        {8'd1, 8'h20, 32'h0000_0038, 32'h0000_0038},  // R1 ch1 control
        {8'd1, 8'h20, 32'h0000_0000, 32'h0000_0000},  // R1
        {8'd1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0003},  // R1 enable width
        {8'd1, 8'h00, 32'h0000_0000, 32'h0000_0000},  // R1
        {8'd2, 8'h08, 32'h0000_0005, 32'h0000_0000},  // R2 hole
        {8'd2, 8'h0C, 32'h0000_0005, 32'h0000_0000},  // R2 hole
        {8'd2, 8'h18, 32'h0000_0055, 32'h0000_0000},  // R2 count read-only
        {8'd2, 8'h28, 32'h0000_00AA, 32'h0000_0000},  // R2 count read-only
        {8'd2, 8'h30, 32'h0000_00FF, 32'h0000_0000},  // R2 absent channel
        {8'd2, 8'h34, 32'h0000_00FF, 32'h0000_0000},  // R2 absent channel
        {8'd9, 8'h04, 32'h0000_0003, 32'h0000_0000}   // R9 clearing idle flags
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(req, rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic tk(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = m;
            @(negedge clk); tick = '0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk_reg("R12 ie", 8'h00, 32'h0);
        chk_reg("R12 status", 8'h04, 32'h0);
        chk_reg("R12 ctl0", 8'h10, 32'h0);
        chk_reg("R12 cnt0", 8'h18, 32'h0);
        chk_irq("R12 irq", 1'b0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            chk_reg($sformatf("R%0d table %0d", VEC[i][79:72], i), VEC[i][71:64], VEC[i][31:0]);
        end

        // R3 / R4 repeating run on source 0
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h03);
        chk_reg("R3 load pending", 8'h10, 32'h03);
        tk(4'b0001, 1);
        chk_reg("R3 loaded count", 8'h18, 32'd3);
        chk_reg("R3 load bit clears", 8'h10, 32'h01);
        tk(4'b0010, 1);
        chk_reg("R6 other source ignored", 8'h18, 32'd3);
        tk(4'b0001, 3);
        chk_reg("R4 counted to zero", 8'h18, 32'd0);
        chk_reg("R4 no early expiry", 8'h04, 32'd0);
        tk(4'b0001, 1);
        chk_reg("R4 reload on expiry", 8'h18, 32'd3);
        chk_reg("R9 status without enable", 8'h04, 32'd1);
        chk_irq("R10 masked", 1'b0);
        wr(8'h00, 32'd1);
        chk_irq("R10 enabled", 1'b1);
        wr(8'h04, 32'd1);
        chk_reg("R9 write-one clears", 8'h04, 32'd0);
        chk_irq("R10 after clear", 1'b0);
        tk(4'b0001, 3);
        // R9 clear and expiry in the same cycle
        @(negedge clk);
        we = 1'b1; addr = 8'h04; wdata = 32'd1; tick = 4'b0001;
        @(negedge clk);
        we = 1'b0; tick = '0;
        chk_reg("R9 set beats clear", 8'h04, 32'd1);
        wr(8'h04, 32'd1);

        // R8 disable window, count is 3
        wr(8'h10, 32'h00);
        tk(4'b0001, 3);
        chk_reg("R8 one more count then halt", 8'h18, 32'd2);

        // R7 divide by 4
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h23);
        tk(4'b0001, 3);
        chk_reg("R7 no pass before fourth tick", 8'h10, 32'h23);
        tk(4'b0001, 1);
        chk_reg("R7 fourth tick loads", 8'h18, 32'd2);
        tk(4'b0001, 4);
        chk_reg("R7 one step per four", 8'h18, 32'd1);
        tk(4'b0001, 3);
        chk_reg("R7 held between passes", 8'h18, 32'd1);
        wr(8'h10, 32'h20);
        tk(4'b0001, 3);
        chk_reg("R8 drain tick counts once", 8'h18, 32'd0);

        // R5 single shot
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h83);
        tk(4'b0001, 4);
        chk_reg("R5 before expiry", 8'h04, 32'd0);
        tk(4'b0001, 1);
        chk_reg("R5 expiry flag", 8'h04, 32'd1);
        chk_reg("R5 enable cleared", 8'h10, 32'h80);
        chk_irq("R10 single-shot irq", 1'b1);
        wr(8'h04, 32'd1);
        tk(4'b0001, 3);
        chk_reg("R5 stays at zero", 8'h18, 32'd0);
        chk_reg("R5 no second expiry", 8'h04, 32'd0);

        // R11 free-running channel 1 on source 1
        wr(8'h20, 32'h07);
        tk(4'b0010, 3);
        chk_reg("R11 inverse timestamp", 8'h28, ~32'd2);
        chk_reg("R3 ch1 load bit clears", 8'h20, 32'h05);
        tk(4'b0001, 2);
        chk_reg("R6 ch1 ignores source 0", 8'h28, ~32'd2);

        finish_run();
    end
endmodule